// File: doc/BRIEF.md
# SIMD Radix-2 SRT Integer Divider

This block divides unsigned integers one quotient digit per clock using the radix-2 SRT method. The partial remainder lives in carry-save form (a sum vector and a carry vector), so each step is a three-input carry-save add whose digit choice looks only at the four top bits of the two vectors. No carry-propagate adder sits in the iteration loop. A single full-width add, done once at the end, resolves the remainder. Before the loop starts, each lane shifts its divisor left until its leading one reaches the lane's top bit. The dividend is shifted by the same amount. After the resolve step the remainder is shifted back right.

The 64-bit operand pair can be treated as one 64-bit division, two 32-bit divisions, four 16-bit divisions or eight 8-bit divisions, chosen by `mode` when `start` is accepted. Each lane runs its own recurrence on its own slice of the operands, and no sum or carry crosses a lane edge. A lane whose divisor is zero reports a fixed result and raises its own flag.

A controller sequences the lanes through four states. In IDLE, `start` takes the transition "accept", which loads the lanes, and the controller enters ITER. ITER takes "step" once per cycle and stays there until a lane-width count of steps is reached. "last step" then leads to FIX, which does the one-time resolve and correction. "resolve" leads to DONE, which raises `done` for one cycle. "retire" returns to IDLE.

Top module: `srt_simd_divider`

## Requirements
- R1: When `start` is high in a cycle where the block is idle, the operands and `mode` are captured at that clock edge. `busy` is high for the following n+1 cycles, where n is the lane width, and low otherwise.
- R2: `done` is high for exactly one cycle. That cycle begins n+1 clock edges after the accepting edge (n = 8, 16, 32, 64 for mode 0, 1, 2, 3), and `busy` is low during it.
- R3: `mode` encoding: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes, 3 gives one 64-bit lane. Lane i occupies bits [i*w +: w] of every operand and result, with w the lane width.
- R4: For each lane with a nonzero divisor, the quotient field equals the floor of dividend / divisor.
- R5: For each lane with a nonzero divisor, the remainder field equals dividend - quotient*divisor, which is always below the divisor.
- R6: A lane with a zero divisor returns an all-ones quotient and its own dividend as remainder, and sets `div_zero[i]`. Other lanes are unaffected.
- R7: `div_zero` bits at or above the active lane count are zero, and a lane with a nonzero divisor has its flag clear.
- R8: `start` while `busy` is high has no effect: the running operation's results and timing are unchanged.
- R9: Results stay stable from the `done` cycle until the next accepted `start`, whatever the operand inputs do.
- R10: After reset, `busy`, `done`, `quotient`, `remainder` and `div_zero` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; taken only when idle |
| mode | input | 2 | Lane split: 0=8x8, 1=4x16, 2=2x32, 3=1x64 |
| dividend | input | 64 | Packed dividends, lane i in bits [i*w +: w] |
| divisor | input | 64 | Packed divisors, same packing |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Packed per-lane quotients |
| remainder | output | 64 | Packed per-lane remainders |
| div_zero | output | 8 | Per-lane zero-divisor flags, bit i for lane i |

## Verification
Each mode is driven with divisors whose leading one is placed at random depths within every lane. This separates a wrong normalisation shift or a wrong shift back of the remainder from a plain recurrence error. Boundary pairs are mixed in: all-ones divided by one, equal operands, a divisor larger than the dividend, and a divisor of one below a top-bit dividend. These make the final remainder land on zero, or require the negative-remainder correction, so they expose faults in the correction step and in the quotient decrement. A zero divisor placed in a single lane of a multi-lane word shows whether lanes stay isolated. A `start` pulse issued mid-operation, and operands that change after completion, show whether captured results can be disturbed.

// File: rtl/srt_pkg.sv
package srt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_FIX,
        ST_DONE
    } ctl_state_t;

    typedef enum logic [1:0] {
        DIG_ZERO,
        DIG_POS,
        DIG_NEG
    } digit_t;

    // Digit choice from the 4-bit carry-save estimate of twice the
    // remainder, in units of half the normalised divisor scale.
    function automatic digit_t pick_digit(input logic [3:0] est);
        if (!est[3])
            return DIG_POS;
        else if (est == 4'b1111)
            return DIG_ZERO;
        else
            return DIG_NEG;
    endfunction

endpackage

// File: rtl/srt_csa.sv
module srt_csa #(
    parameter int W = 11
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] maj;

    always_comb begin
        s   = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        c   = {maj[W-2:0], cin};
    end
endmodule

// File: rtl/srt_lane.sv
module srt_lane #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         fin,
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] quo,
    output logic [N-1:0] rem,
    output logic         dz
);
    import srt_pkg::*;

    localparam int SHW = (N > 1) ? $clog2(N) : 1;
    localparam int RW  = N + 3;

    logic [RW-1:0]  ps, pc;
    logic [N-1:0]   tail, dn, pos_v, neg_v, a_keep;
    logic [SHW-1:0] sh;
    logic           zero_d;

    logic [SHW-1:0] sh_n;
    logic [2*N-1:0] wide;
    logic [RW-1:0]  s2, c2, yv, s_nx, c_nx, rr, rfix;
    logic [3:0]     est;
    digit_t         dig;
    logic           rneg;
    logic [N-1:0]   qfix, rsh;

    function automatic logic [SHW-1:0] lead_zeros(input logic [N-1:0] v);
        logic [SHW-1:0] cnt;
        cnt = '0;
        for (int i = 0; i < N; i++)
            if (v[i]) cnt = SHW'(N - 1 - i);
        return cnt;
    endfunction

    // normalisation of the incoming operands
    always_comb begin
        sh_n = lead_zeros(d_in);
        wide = {{N{1'b0}}, a_in} << sh_n;
    end

    // one recurrence step: double, shift in a dividend bit, pick digit
    always_comb begin
        s2  = {ps[RW-2:0], tail[N-1]};
        c2  = {pc[RW-2:0], 1'b0};
        est = s2[N+2:N-1] + c2[N+2:N-1];
        dig = pick_digit(est);
        unique case (dig)
            DIG_POS: yv = ~{3'b000, dn};
            DIG_NEG: yv = {3'b000, dn};
            default: yv = '0;
        endcase
    end

    srt_csa #(.W(RW)) u_csa (
        .x   (s2),
        .y   (c2),
        .z   (yv),
        .cin (dig == DIG_POS),
        .s   (s_nx),
        .c   (c_nx)
    );

    // final resolve, sign correction and de-normalisation
    always_comb begin
        rr   = ps + pc;
        rneg = rr[RW-1];
        rfix = rneg ? rr + {3'b000, dn} : rr;
        qfix = pos_v - neg_v - {{(N-1){1'b0}}, rneg};
        rsh  = rfix[N-1:0] >> sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps     <= '0;
            pc     <= '0;
            tail   <= '0;
            dn     <= '0;
            sh     <= '0;
            pos_v  <= '0;
            neg_v  <= '0;
            a_keep <= '0;
            zero_d <= 1'b0;
            quo    <= '0;
            rem    <= '0;
            dz     <= 1'b0;
        end else if (load) begin
            ps     <= {3'b000, wide[2*N-1:N]};
            pc     <= '0;
            tail   <= wide[N-1:0];
            dn     <= d_in << sh_n;
            sh     <= sh_n;
            pos_v  <= '0;
            neg_v  <= '0;
            a_keep <= a_in;
            zero_d <= (d_in == '0);
        end else if (step) begin
            ps    <= s_nx;
            pc    <= c_nx;
            tail  <= tail << 1;
            pos_v <= {pos_v[N-2:0], dig == DIG_POS};
            neg_v <= {neg_v[N-2:0], dig == DIG_NEG};
        end else if (fin) begin
            if (zero_d) begin
                quo <= '1;
                rem <= a_keep;
                dz  <= 1'b1;
            end else begin
                quo <= qfix;
                rem <= rsh;
                dz  <= 1'b0;
            end
        end
    end

    // R4: the remainder estimate stays inside the SRT convergence band
    p_est_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($signed(est) <= 4'sd3 && $signed(est) >= -4'sd5));

    // R5: the corrected remainder fits below the normalised divisor width
    p_fix_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !zero_d |-> (rfix[RW-1:N] == '0 && rfix[N-1:0] < dn));

    // R5: published remainder is below the lane divisor
    p_rem_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (dz || rem < (dn >> sh)));
endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl #(
    parameter int LANE_MIN = 8,
    parameter int MODES    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(MODES)-1:0] mode_in,
    output logic [$clog2(MODES)-1:0] mode_q,
    output logic                     busy,
    output logic                     done,
    output logic                     load,
    output logic                     step,
    output logic                     fin
);
    import srt_pkg::*;

    localparam int MW   = $clog2(MODES);
    localparam int MAXW = LANE_MIN << (MODES - 1);
    localparam int CW   = $clog2(MAXW);

    ctl_state_t    state, state_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                cnt    <= CW'((LANE_MIN << mode_in) - 1);
                mode_q <= mode_in;
            end else if (state == ST_ITER) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_ITER;
            ST_ITER: if (cnt == '0) state_nx = ST_FIX;
            ST_FIX:  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (state == ST_IDLE) && start;
        step = (state == ST_ITER);
        fin  = (state == ST_FIX);
        busy = (state == ST_ITER) || (state == ST_FIX);
        done = (state == ST_DONE);
    end

    // R1: an accepted start makes the block busy on the next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> busy);

    // R2: completion is a single-cycle pulse, never overlapping busy
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a start during an operation leaves the captured mode alone
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mode_q));
endmodule

// File: rtl/srt_simd_divider.sv
module srt_simd_divider #(
    parameter int LANE_MIN = 8,
    parameter int MODES    = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [$clog2(MODES)-1:0]            mode,
    input  logic [(LANE_MIN<<(MODES-1))-1:0]    dividend,
    input  logic [(LANE_MIN<<(MODES-1))-1:0]    divisor,
    output logic                                busy,
    output logic                                done,
    output logic [(LANE_MIN<<(MODES-1))-1:0]    quotient,
    output logic [(LANE_MIN<<(MODES-1))-1:0]    remainder,
    output logic [(1<<(MODES-1))-1:0]           div_zero
);
    localparam int MW   = $clog2(MODES);
    localparam int DW   = LANE_MIN << (MODES - 1);
    localparam int MAXL = 1 << (MODES - 1);

    logic [MW-1:0]   mode_q;
    logic            load, step, fin;
    logic [DW-1:0]   q_grp [MODES];
    logic [DW-1:0]   r_grp [MODES];
    logic [MAXL-1:0] z_grp [MODES];

    srt_ctrl #(.LANE_MIN(LANE_MIN), .MODES(MODES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (mode),
        .mode_q  (mode_q),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .step    (step),
        .fin     (fin)
    );

    for (genvar g = 0; g < MODES; g++) begin : g_mode
        localparam int LW = LANE_MIN << g;
        localparam int LN = MAXL >> g;

        logic            ld_g, st_g, fn_g;
        logic [DW-1:0]   qv, rv;
        logic [MAXL-1:0] zv;

        assign ld_g = load && (mode == MW'(g));
        assign st_g = step && (mode_q == MW'(g));
        assign fn_g = fin && (mode_q == MW'(g));

        for (genvar k = 0; k < LN; k++) begin : g_lane
            srt_lane #(.N(LW)) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (ld_g),
                .step  (st_g),
                .fin   (fn_g),
                .a_in  (dividend[k*LW +: LW]),
                .d_in  (divisor[k*LW +: LW]),
                .quo   (qv[k*LW +: LW]),
                .rem   (rv[k*LW +: LW]),
                .dz    (zv[k])
            );
        end

        if (LN < MAXL) begin : g_pad
            assign zv[MAXL-1:LN] = '0;
        end

        assign q_grp[g] = qv;
        assign r_grp[g] = rv;
        assign z_grp[g] = zv;
    end

    always_comb begin
        quotient  = q_grp[mode_q];
        remainder = r_grp[mode_q];
        div_zero  = z_grp[mode_q];
    end

    // R7: no flag is raised for a lane slot the active mode does not use
    p_dz_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((div_zero >> (MAXL >> mode_q)) == '0));

    // R9: results do not move while idle
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/srt_simd_divider_test.sv
`timescale 1ns/1ps
module srt_simd_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [63:0] dvd = '0;
    logic [63:0] dvs = '0;
    logic        busy, done;
    logic [63:0] quotient, remainder;
    logic [7:0]  div_zero;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int          t = 0;
    int          n_cur = 8;
    logic [63:0] la = '0, ld = '0;
    logic [1:0]  lm = '0;
    logic [63:0] eq = '0, er = '0;
    logic [7:0]  ez = '0;

    always #2.5 clk = ~clk;

    srt_simd_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .dividend  (dvd),
        .divisor   (dvs),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero)
    );

    task automatic ref_div(input logic [63:0] a, input logic [63:0] d, input logic [1:0] m,
                           output logic [63:0] q, output logic [63:0] r, output logic [7:0] z);
        int w;
        int cnt;
        logic [63:0] mask, av, dv;
        w = 8 << m;
        cnt = 8 >> m;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        q = '0;
        r = '0;
        z = '0;
        for (int i = 0; i < cnt; i++) begin
            av = (a >> (i * w)) & mask;
            dv = (d >> (i * w)) & mask;
            if (dv == 0) begin
                q = q | (mask << (i * w));
                r = r | (av << (i * w));
                z[i] = 1'b1;
            end else begin
                q = q | ((av / dv) << (i * w));
                r = r | ((av % dv) << (i * w));
            end
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural timing model: t counts edges since the accepting edge
    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0;
            eq = '0;
            er = '0;
            ez = '0;
        end else if (t == 0) begin
            if (start) begin
                t = 1;
                la = dvd;
                ld = dvs;
                lm = mode;
                n_cur = 8 << mode;
            end
        end else if (t == n_cur + 2) begin
            t = 0;
        end else begin
            t++;
            if (t == n_cur + 2) ref_div(la, ld, lm, eq, er, ez);
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 busy", {63'd0, busy}, {63'd0, (t >= 1 && t <= n_cur + 1)});
            chk("R2 done", {63'd0, done}, {63'd0, (t == n_cur + 2)});
            if (t == 0 || t == n_cur + 2) begin
                chk("R4 quotient", quotient, eq);
                chk("R5 remainder", remainder, er);
                chk("R6 div_zero", {56'd0, div_zero}, {56'd0, ez});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R2 watchdog: done actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic op(input logic [63:0] a, input logic [63:0] d, input logic [1:0] m);
        @(negedge clk);
        dvd = a;
        dvs = d;
        mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (t != n_cur + 2) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [63:0] rnd_div(input logic [1:0] m);
        logic [63:0] v;
        int w;
        w = 8 << m;
        v = rnd64();
        for (int i = 0; i < (8 >> m); i++) begin
            logic [63:0] mask;
            mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            v = (v & ~(mask << (i * w))) |
                ((((v >> (i * w)) & mask) >> ($urandom % w)) << (i * w));
        end
        return v;
    endfunction

    initial begin
        logic [63:0] q0, r0, sq;
        logic [7:0]  z0;
        int          lat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 busy", {63'd0, busy}, 64'd0);
        chk("R10 done", {63'd0, done}, 64'd0);
        chk("R10 quotient", quotient, 64'd0);
        chk("R10 remainder", remainder, 64'd0);
        chk("R10 div_zero", {56'd0, div_zero}, 64'd0);

        // R3: lane packing in mode 1, expected values worked by hand
        op({16'd65535, 16'd3000, 16'd2000, 16'd1000}, {16'd255, 16'd7, 16'd3, 16'd10}, 2'd1);
        chk("R3 quotient lanes", quotient, {16'd257, 16'd428, 16'd666, 16'd100});
        chk("R3 remainder lanes", remainder, {16'd0, 16'd4, 16'd2, 16'd0});

        // R6: zero divisor in lane 2 only, mode 0
        op(64'h1122_3344_5566_7788, 64'h0303_0303_0300_0303, 2'd0);
        chk("R6 flag lane 2", {56'd0, div_zero}, 64'h04);
        chk("R6 lane2 quotient", {56'd0, quotient[23:16]}, 64'hff);
        chk("R6 lane2 remainder", {56'd0, remainder[23:16]}, 64'h66);

        // R7: single wide lane with zero divisor flags only bit 0
        op(64'hdead_beef_0000_0001, 64'd0, 2'd3);
        chk("R7 flag 1x64", {56'd0, div_zero}, 64'h01);
        op(64'hffff_ffff_ffff_ffff, 64'h0101_0101_0101_0101, 2'd0);
        chk("R7 no flags", {56'd0, div_zero}, 64'h00);

        // R2: latency per mode
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            dvd = rnd64();
            dvs = rnd_div(2'(m));
            mode = 2'(m);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat = 0;
            while (!done) begin
                @(negedge clk);
                lat++;
            end
            chk("R2 latency", 64'(lat), 64'((8 << m) + 1));
            @(negedge clk);
        end

        // R4/R5 boundaries in every mode
        for (int m = 0; m < 4; m++) begin
            op('1, {8{8'h01}}, 2'(m));
            op(64'h8000_0000_8000_8080, 64'h7fff_ffff_7fff_7f7f, 2'(m));
            op(64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef, 2'(m));
            op(64'h0001_0001_0001_0101, 64'hffff_ffff_ffff_ffff, 2'(m));
            op('1, 64'h0303_0303_0303_0303, 2'(m));
            op(64'hfedc_ba98_7654_3210, 64'h4000_4000_4000_4040, 2'(m));
        end

        // R8: start during busy is ignored
        ref_div(64'h9999_8888_7777_6666, 64'h0505_0505_0505_0505, 2'd2, q0, r0, z0);
        @(negedge clk);
        dvd = 64'h9999_8888_7777_6666;
        dvs = 64'h0505_0505_0505_0505;
        mode = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        dvd = 64'h1;
        dvs = 64'h0;
        mode = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (t != n_cur + 2) @(negedge clk);
        chk("R8 quotient", quotient, q0);
        chk("R8 remainder", remainder, r0);
        @(negedge clk);

        // R9: results hold while inputs wander
        sq = quotient;
        for (int i = 0; i < 10; i++) begin
            dvd = rnd64();
            dvs = rnd64();
            mode = 2'($urandom % 4);
            @(negedge clk);
        end
        chk("R9 held quotient", quotient, sq);
        chk("R9 held remainder", remainder, r0);

        // R4/R5: randomised operands with varied divisor magnitudes
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 40; i++) begin
                op(rnd64(), rnd_div(2'(m)), 2'(m));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule